// File: doc/BRIEF.md
# Operand-Capturing Issue Queue

This block sits between the rename stage and one execution unit of an out-of-order core. Each incoming instruction brings an opcode and a fixed number of source operands. Each operand comes either as a finished value or as a pending tag that names the result it still waits for. The queue stores the operand values inside its own slots. It snoops a single result broadcast bus, and when a pending tag matches, it copies the broadcast value into the waiting slot.

An entry becomes eligible once every operand holds a value. Each cycle the queue picks the eligible entry that entered earliest and drives its opcode and operand values to the execution unit on registered outputs, then frees the slot. Because entries leave out of order, a freed slot can be taken by a newer instruction. Selection therefore follows an age rank kept with each entry and not the slot position, so a waiting old instruction can never be starved. A flush input empties the queue.

Top module: `rs_issue_queue`

## Requirements
- R1: After reset `iss_valid` is 0 and `in_ready` is 1.
- R2: An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both 1, at most one per edge. An accepted instruction whose operands are all ready shows on the issue outputs after the next edge.
- R3: An operand whose `in_rdy` bit is 1 reaches `iss_ops` unchanged. Operand k occupies bits `[k*DATA_W +: DATA_W]` of both `in_val` and `iss_ops`, and its tag occupies `in_tag[k*TAG_W +: TAG_W]`.
- R4: A stored pending operand takes `bc_val` on an edge where `bc_valid` is 1 and `bc_tag` equals its tag. A broadcast with a different tag leaves it pending and unchanged.
- R5: An entry is not issued while any of its operands is still pending.
- R6: A broadcast on the same edge that selects an entry counts as ready for that entry. The issued operand carries `bc_val` directly.
- R7: An operand that arrives pending, with a tag equal to a broadcast on its insertion edge, is captured at insertion.
- R8: Among eligible entries, the one accepted earliest is issued first, whatever slot it occupies.
- R9: Entries leave in any order. A younger eligible entry issues ahead of an older pending one, and its freed slot can be reused.
- R10: With DEPTH entries held, `in_ready` is 0 and an instruction offered on `in_valid` is dropped.
- R11: A flush edge discards every held entry and suppresses issue on that edge. `in_ready` is 1 afterwards.
- R12: At most one entry issues per edge, and each accepted entry issues exactly once, with `iss_valid` high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all held entries |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | A free slot exists |
| in_opc | input | OPC_W | Opcode of offered instruction |
| in_rdy | input | OPS | Per-operand flag: 1 means value present |
| in_tag | input | OPS*TAG_W | Per-operand pending tag |
| in_val | input | OPS*DATA_W | Per-operand value |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Broadcast result tag |
| bc_val | input | DATA_W | Broadcast result value |
| iss_valid | output | 1 | Issue outputs carry an instruction |
| iss_opc | output | OPC_W | Issued opcode |
| iss_ops | output | OPS*DATA_W | Issued operand values |

## Verification
The hardest case to reach is an older entry sitting in a higher slot than a younger one, since plain in-order filling keeps age and slot index aligned. The stimulus first issues a ready instruction so that slot 0 empties. It then inserts a second pending instruction, which lands in that lower slot, and releases both with one broadcast. Slot-index priority would then pick the wrong entry. A second hard case is capture without issue. It needs an entry with two pending operands, so that the first broadcast fills one slot while the entry stays blocked.

// File: rtl/rsiq_pkg.sv
package rsiq_pkg;
  localparam int RSIQ_DEPTH  = 8;
  localparam int RSIQ_OPS    = 2;
  localparam int RSIQ_DATA_W = 16;
  localparam int RSIQ_TAG_W  = 5;
  localparam int RSIQ_OPC_W  = 4;
endpackage

// File: rtl/rsiq_slot.sv
module rsiq_slot
  import rsiq_pkg::*;
#(
  parameter int OPS    = RSIQ_OPS,
  parameter int DATA_W = RSIQ_DATA_W,
  parameter int TAG_W  = RSIQ_TAG_W,
  parameter int OPC_W  = RSIQ_OPC_W,
  parameter int AGE_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  alloc,
  input  logic [OPC_W-1:0]      alloc_opc,
  input  logic [OPS-1:0]        alloc_rdy,
  input  logic [OPS*TAG_W-1:0]  alloc_tag,
  input  logic [OPS*DATA_W-1:0] alloc_val,
  input  logic [AGE_W-1:0]      alloc_age,
  input  logic                  bc_valid,
  input  logic [TAG_W-1:0]      bc_tag,
  input  logic [DATA_W-1:0]     bc_val,
  input  logic                  grant,
  input  logic                  iss_fire,
  input  logic [AGE_W-1:0]      iss_age,
  output logic                  valid,
  output logic                  eligible,
  output logic [AGE_W-1:0]      age,
  output logic [OPC_W-1:0]      opc,
  output logic [OPS*DATA_W-1:0] fwd_val
);
  logic              vld_q;
  logic [OPC_W-1:0]  opc_q;
  logic [AGE_W-1:0]  age_q;
  logic              rdy_q [OPS];
  logic [TAG_W-1:0]  tag_q [OPS];
  logic [DATA_W-1:0] val_q [OPS];
  logic [OPS-1:0]    hit, op_ok, ins_hit;

  for (genvar g = 0; g < OPS; g++) begin : g_op
    assign hit[g]     = vld_q && !rdy_q[g] && bc_valid && (tag_q[g] == bc_tag);
    assign op_ok[g]   = rdy_q[g] || hit[g];
    assign ins_hit[g] = !alloc_rdy[g] && bc_valid && (alloc_tag[g*TAG_W +: TAG_W] == bc_tag);
    assign fwd_val[g*DATA_W +: DATA_W] = hit[g] ? bc_val : val_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      opc_q <= '0;
      age_q <= '0;
      for (int i = 0; i < OPS; i++) begin
        rdy_q[i] <= 1'b0;
        tag_q[i] <= '0;
        val_q[i] <= '0;
      end
    end else if (flush) begin
      vld_q <= 1'b0;
    end else if (alloc) begin
      vld_q <= 1'b1;
      opc_q <= alloc_opc;
      age_q <= alloc_age;
      for (int i = 0; i < OPS; i++) begin
        tag_q[i] <= alloc_tag[i*TAG_W +: TAG_W];
        rdy_q[i] <= alloc_rdy[i] || ins_hit[i];
        val_q[i] <= alloc_rdy[i] ? alloc_val[i*DATA_W +: DATA_W] : bc_val;
      end
    end else if (grant) begin
      vld_q <= 1'b0;
    end else if (vld_q) begin
      if (iss_fire && (age_q > iss_age)) age_q <= age_q - 1'b1;
      for (int i = 0; i < OPS; i++) begin
        if (hit[i]) begin
          rdy_q[i] <= 1'b1;
          val_q[i] <= bc_val;
        end
      end
    end
  end

  assign valid    = vld_q;
  assign eligible = vld_q && (&op_ok);
  assign age      = age_q;
  assign opc      = opc_q;
endmodule

// File: rtl/rsiq_pick.sv
module rsiq_pick #(
  parameter int N     = 8,
  parameter int AGE_W = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       elig,
  input  logic [N*AGE_W-1:0] age_flat,
  output logic [N-1:0]       grant,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  logic [AGE_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!any || (age_flat[i*AGE_W +: AGE_W] < best))) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        best = age_flat[i*AGE_W +: AGE_W];
      end
    end
    grant = '0;
    if (any) grant[idx] = 1'b1;
  end
endmodule

// File: rtl/rs_issue_queue.sv
module rs_issue_queue
  import rsiq_pkg::*;
#(
  parameter int DEPTH  = RSIQ_DEPTH,
  parameter int OPS    = RSIQ_OPS,
  parameter int DATA_W = RSIQ_DATA_W,
  parameter int TAG_W  = RSIQ_TAG_W,
  parameter int OPC_W  = RSIQ_OPC_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [OPC_W-1:0]      in_opc,
  input  logic [OPS-1:0]        in_rdy,
  input  logic [OPS*TAG_W-1:0]  in_tag,
  input  logic [OPS*DATA_W-1:0] in_val,
  input  logic                  bc_valid,
  input  logic [TAG_W-1:0]      bc_tag,
  input  logic [DATA_W-1:0]     bc_val,
  output logic                  iss_valid,
  output logic [OPC_W-1:0]      iss_opc,
  output logic [OPS*DATA_W-1:0] iss_ops
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int AGE_W = IDX_W;

  logic [DEPTH-1:0]       valid_vec, elig_vec, pick_vec, grant_vec;
  logic [DEPTH*AGE_W-1:0] age_flat;
  logic [OPC_W-1:0]       opc_arr [DEPTH];
  logic [OPS*DATA_W-1:0]  fwd_arr [DEPTH];
  logic                   pick_any, iss_fire, accept, full;
  logic [IDX_W-1:0]       pick_idx, free_idx;
  logic [AGE_W-1:0]       occ, new_age, iss_age;

  always_comb begin
    free_idx = '0;
    occ      = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
      if (valid_vec[i])  occ = occ + 1'b1;
    end
  end

  assign full      = &valid_vec;
  assign in_ready  = !full;
  assign accept    = in_valid && !full && !flush;
  assign iss_fire  = pick_any && !flush;
  assign grant_vec = pick_vec & {DEPTH{iss_fire}};
  assign iss_age   = age_flat[pick_idx*AGE_W +: AGE_W];
  assign new_age   = occ - AGE_W'(iss_fire);

  rsiq_pick #(.N(DEPTH), .AGE_W(AGE_W)) pick_i (
    .elig(elig_vec), .age_flat(age_flat),
    .grant(pick_vec), .any(pick_any), .idx(pick_idx)
  );

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    rsiq_slot #(
      .OPS(OPS), .DATA_W(DATA_W), .TAG_W(TAG_W), .OPC_W(OPC_W), .AGE_W(AGE_W)
    ) slot_i (
      .clk(clk), .rst(rst), .flush(flush),
      .alloc(accept && (free_idx == IDX_W'(s))),
      .alloc_opc(in_opc), .alloc_rdy(in_rdy), .alloc_tag(in_tag),
      .alloc_val(in_val), .alloc_age(new_age),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .grant(grant_vec[s]), .iss_fire(iss_fire), .iss_age(iss_age),
      .valid(valid_vec[s]), .eligible(elig_vec[s]),
      .age(age_flat[s*AGE_W +: AGE_W]),
      .opc(opc_arr[s]), .fwd_val(fwd_arr[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
      iss_opc   <= '0;
      iss_ops   <= '0;
    end else begin
      iss_valid <= iss_fire;
      if (iss_fire) begin
        iss_opc <= opc_arr[pick_idx];
        iss_ops <= fwd_arr[pick_idx];
      end
    end
  end
endmodule

// File: rtl/rsiq_checker.sv
module rsiq_checker #(
  parameter int DEPTH = 8,
  parameter int AGE_W = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   flush,
  input logic                   iss_valid,
  input logic                   in_ready,
  input logic [DEPTH-1:0]       valid_vec,
  input logic [DEPTH-1:0]       elig_vec,
  input logic [DEPTH-1:0]       grant_vec,
  input logic [DEPTH*AGE_W-1:0] age_flat
);
  logic older_skipped;

  always_comb begin
    older_skipped = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      for (int j = 0; j < DEPTH; j++)
        if (grant_vec[i] && elig_vec[j] &&
            (age_flat[j*AGE_W +: AGE_W] < age_flat[i*AGE_W +: AGE_W]))
          older_skipped = 1'b1;
  end

  a_r12_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_vec));

  a_r5_grant_eligible: assert property (@(posedge clk) disable iff (rst)
    (grant_vec & ~elig_vec) == '0);

  a_r8_oldest_first: assert property (@(posedge clk) disable iff (rst)
    !older_skipped);

  a_r11_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_vec == '0) && !iss_valid && in_ready);

  a_r10_full_holds: assert property (@(posedge clk) disable iff (rst)
    ((&valid_vec) && (grant_vec == '0) && !flush) |=> (&valid_vec) && !in_ready);
endmodule

bind rs_issue_queue rsiq_checker #(.DEPTH(DEPTH), .AGE_W(AGE_W)) chk_i (
  .clk(clk), .rst(rst), .flush(flush), .iss_valid(iss_valid),
  .in_ready(in_ready), .valid_vec(valid_vec), .elig_vec(elig_vec),
  .grant_vec(grant_vec), .age_flat(age_flat)
);

// File: tb/rs_issue_queue_tb_top.sv
module rs_issue_queue_tb_top;
  localparam int DEPTH  = 8;
  localparam int OPS    = 2;
  localparam int DATA_W = 16;
  localparam int TAG_W  = 5;
  localparam int OPC_W  = 4;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  flush = 1'b0;
  logic                  in_valid = 1'b0;
  logic                  in_ready;
  logic [OPC_W-1:0]      in_opc = '0;
  logic [OPS-1:0]        in_rdy = '0;
  logic [OPS*TAG_W-1:0]  in_tag = '0;
  logic [OPS*DATA_W-1:0] in_val = '0;
  logic                  bc_valid = 1'b0;
  logic [TAG_W-1:0]      bc_tag = '0;
  logic [DATA_W-1:0]     bc_val = '0;
  logic                  iss_valid;
  logic [OPC_W-1:0]      iss_opc;
  logic [OPS*DATA_W-1:0] iss_ops;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rs_issue_queue #(
    .DEPTH(DEPTH), .OPS(OPS), .DATA_W(DATA_W), .TAG_W(TAG_W), .OPC_W(OPC_W)
  ) dut_i (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic exp_issue(input string req, input logic [OPC_W-1:0] opc,
                           input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    chk(req, "iss_valid", 32'(iss_valid), 32'd1);
    chk(req, "iss_opc", 32'(iss_opc), 32'(opc));
    chk(req, "op0", 32'(iss_ops[0 +: DATA_W]), 32'(a));
    chk(req, "op1", 32'(iss_ops[DATA_W +: DATA_W]), 32'(b));
  endtask

  task automatic exp_idle(input string req);
    chk(req, "iss_valid", 32'(iss_valid), 32'd0);
  endtask

  task automatic offer(input logic [OPC_W-1:0] opc,
                       input logic r0, input logic [TAG_W-1:0] t0, input logic [DATA_W-1:0] v0,
                       input logic r1, input logic [TAG_W-1:0] t1, input logic [DATA_W-1:0] v1);
    in_valid = 1'b1;
    in_opc   = opc;
    in_rdy   = {r1, r0};
    in_tag   = {t1, t0};
    in_val   = {v1, v0};
  endtask

  task automatic bcast(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] v);
    bc_valid = 1'b1;
    bc_tag   = t;
    bc_val   = v;
  endtask

  task automatic quiet();
    in_valid = 1'b0;
    bc_valid = 1'b0;
    flush    = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    chk("R1", "iss_valid", 32'(iss_valid), 32'd0);
    chk("R1", "in_ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_basic();
    offer(4'd3, 1'b1, 5'd0, 16'hA1A1, 1'b1, 5'd0, 16'hB2B2);
    tick(); quiet();
    exp_idle("R2");
    tick();
    exp_issue("R3", 4'd3, 16'hA1A1, 16'hB2B2);
    tick();
    exp_idle("R12");
  endtask

  task automatic t_capture();
    offer(4'd7, 1'b0, 5'd5, 16'h0000, 1'b0, 5'd6, 16'h0000);
    tick(); quiet();
    bcast(5'd9, 16'hDEAD);
    tick(); quiet();
    exp_idle("R4");
    bcast(5'd5, 16'h0055);
    tick(); quiet();
    exp_idle("R5");
    tick();
    exp_idle("R5");
    bcast(5'd6, 16'h0066);
    tick(); quiet();
    exp_issue("R6", 4'd7, 16'h0055, 16'h0066);
    tick();
    exp_idle("R12");
  endtask

  task automatic t_insert_capture();
    offer(4'd9, 1'b0, 5'd3, 16'h0000, 1'b1, 5'd0, 16'h0044);
    bcast(5'd3, 16'h0033);
    tick(); quiet();
    exp_idle("R7");
    tick();
    exp_issue("R7", 4'd9, 16'h0033, 16'h0044);
    tick();
  endtask

  task automatic t_age_over_slot();
    offer(4'd1, 1'b1, 5'd0, 16'h1111, 1'b1, 5'd0, 16'h1112);
    tick();
    offer(4'd2, 1'b0, 5'd4, 16'h0000, 1'b1, 5'd0, 16'h2222);
    tick(); quiet();
    exp_issue("R9", 4'd1, 16'h1111, 16'h1112);
    offer(4'd3, 1'b0, 5'd4, 16'h0000, 1'b1, 5'd0, 16'h3333);
    tick(); quiet();
    exp_idle("R9");
    bcast(5'd4, 16'h0404);
    tick(); quiet();
    exp_issue("R8", 4'd2, 16'h0404, 16'h2222);
    tick();
    exp_issue("R8", 4'd3, 16'h0404, 16'h3333);
    tick();
    exp_idle("R12");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) begin
      offer(OPC_W'(i), 1'b0, 5'd10, 16'h0000, 1'b1, 5'd0, 16'(i));
      tick();
    end
    quiet();
    chk("R10", "in_ready", 32'(in_ready), 32'd0);
    offer(4'd15, 1'b1, 5'd0, 16'hFFFF, 1'b1, 5'd0, 16'hFFFF);
    tick(); quiet();
    tick();
    exp_idle("R10");
    bcast(5'd10, 16'h0A0A);
    tick(); quiet();
    for (int i = 0; i < DEPTH; i++) begin
      exp_issue("R8", OPC_W'(i), 16'h0A0A, 16'(i));
      tick();
    end
    exp_idle("R10");
    chk("R10", "in_ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_flush();
    offer(4'd12, 1'b0, 5'd12, 16'h0000, 1'b1, 5'd0, 16'h1200);
    tick();
    offer(4'd13, 1'b0, 5'd12, 16'h0000, 1'b1, 5'd0, 16'h1300);
    tick(); quiet();
    flush = 1'b1;
    tick(); quiet();
    chk("R11", "in_ready", 32'(in_ready), 32'd1);
    bcast(5'd12, 16'h0C0C);
    tick(); quiet();
    tick();
    exp_idle("R11");
    offer(4'd14, 1'b1, 5'd0, 16'h1400, 1'b1, 5'd0, 16'h1401);
    tick(); quiet();
    flush = 1'b1;
    tick(); quiet();
    exp_idle("R11");
    tick();
    exp_idle("R11");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_capture();
    t_insert_capture();
    t_age_over_slot();
    t_full();
    t_flush();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule